// File: doc/BRIEF.md
# SPI Slave Port with Word-Pacing Request

This block is the slave side of a serial host port. An external master drives the serial clock, the select line and the data-in line. The block moves fixed-length words between that master and an internal core. On every word the block receives a word from the master and returns a word at the same time. The core loads outgoing words and collects incoming words through a plain parallel interface of data plus one-cycle strobes. All four combinations of clock idle level and sampling phase are supported. Both mode inputs must be held steady while the select line is asserted.

An active-low request output paces the master one word at a time. The request is held high (not ready) while a word is in flight. It is also held high while the core still owes the block a transmit word, or has not yet taken the last received word. In the phase mode that samples on the leading edge, the request also stays high until the master drops the select line, because that mode frames every word with a select pulse. The serial clock, data-in and select inputs are brought into the system clock domain through a parameterised synchroniser chain, and clock edges are detected in that domain. The serial clock must therefore run well below the system clock.

The data output is driven only while the synchronised select is asserted. An output-enable port tells the pad ring when to drive the pin.

Top module: `spi_req_slave`

## Requirements
- R1: Serial clock edges that arrive while the select input is high (deasserted) are ignored. They produce no receive pulse, and the data output stays disabled.
- R2: Received bits are shifted in most-significant bit first. When the last bit of a word is sampled, `rx_data_o` shows the complete word and `rx_valid_o` pulses high for exactly one system clock cycle.
- R3: Transmitted bits leave on `miso_o` most-significant bit first, in all four modes. When `cpha_i`=1, consecutive words may be sent with the select line held low the whole time.
- R4: `miso_oe_o` goes high within SYNC_STAGES+1 cycles after the select input goes low, and goes low within the same delay after the select input goes high.
- R5: `req_n_o` goes high after the first sampling edge of a word and stays high while that word is in flight, including the cycle in which `rx_valid_o` pulses.
- R6: `req_n_o` is low only when all of the following hold: no word is in flight, a transmit word loaded by the core is waiting, and the last received word has been read. When `cpha_i`=0, it also stays high after a word until the select line has been deasserted. Out of reset it is high.
- R7: If no new transmit word has been loaded when a word transfer starts, the previous transmit word is sent again and `tx_underrun_o` pulses for one cycle. A transfer starts at the select assertion when `cpha_i`=0, and at the first leading clock edge of the word when `cpha_i`=1.
- R8: If a word completes while the previous received word is still unread, `rx_overrun_o` pulses one cycle after `rx_valid_o`. `rx_data_o` then holds the newer word.
- R9: `cpol_i` gives the idle clock level. With `cpha_i`=0, data is sampled on the edge leaving the idle level and shifted on the edge returning to it. With `cpha_i`=1 these two roles are swapped.
- R10: Deasserting the select line in the middle of a word discards the partial word. The next word then starts again from bit zero, both for receive and for transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Drive enable for the data-out pad |
| req_n_o | output | 1 | Active-low ready-for-next-word request |
| tx_data_i | input | WORD_W | Word to send next |
| tx_load_i | input | 1 | One-cycle strobe that loads `tx_data_i` |
| tx_underrun_o | output | 1 | One-cycle pulse: previous word re-sent |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse: new word in `rx_data_o` |
| rx_read_i | input | 1 | One-cycle strobe: core has taken `rx_data_o` |
| rx_overrun_o | output | 1 | One-cycle pulse: unread word overwritten |

## Verification
The bench sweeps all four clock modes with an 8-bit word and uses walking patterns at both ends of the word. A design with the sampling and shifting edges swapped would return a word shifted by one bit. The bench checks the request line at three points: inside a word, after a word while the select is still low in leading-edge mode, and after the select rises. A design that re-arms too early would show a low request where a high one is expected. The bench also runs transfers with no fresh transmit word, transfers with an unread receive word, and a word aborted after three bits. These catch a design that sends stale or zero data without flagging it, and a design that keeps the partial bit count so the following word comes out misaligned.

// File: rtl/spi_req_pkg.sv
`timescale 1ns/1ps
package spi_req_pkg;

   // Serial clock transitions relative to the idle level.
   typedef struct packed {
      logic lead;   // leaving the idle level
      logic trail;  // returning to the idle level
   } sck_edge_t;

   function automatic sck_edge_t sck_classify(input logic prev, input logic cur, input logic idle);
      sck_edge_t e;
      e.lead  = (prev == idle) && (cur != idle);
      e.trail = (prev != idle) && (cur == idle);
      return e;
   endfunction

endpackage

// File: rtl/spi_req_sync.sv
`timescale 1ns/1ps
module spi_req_sync #(
   parameter int unsigned WIDTH = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int unsigned CHAIN_W = WIDTH * STAGES;

   logic [CHAIN_W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_req_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
   end

   assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_req_rx.sv
`timescale 1ns/1ps
module spi_req_rx #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic              sample_i,
   input  logic              bit_i,
   output logic              idle_o,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o
);
   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] assembled;
   logic              last;

   assign assembled = {sh_q[WORD_W-2:0], bit_i};
   assign last      = (cnt_q == LAST_IDX);
   assign idle_o    = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (abort_i) begin
         cnt_q <= '0;
      end else if (sample_i) begin
         sh_q  <= assembled;
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= sample_i && !abort_i && last;
         if (sample_i && !abort_i && last) word_o <= assembled;
      end
   end
endmodule

// File: rtl/spi_req_tx.sv
`timescale 1ns/1ps
module spi_req_tx #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              bit_o
);
   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (load_i)  sh_q <= word_i;
      else if (shift_i) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
   end

   assign bit_o = sh_q[WORD_W-1];
endmodule

// File: rtl/spi_req_slave.sv
`timescale 1ns/1ps
module spi_req_slave #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic              sck_i,
   input  logic              mosi_i,
   input  logic              ss_n_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic              req_n_o,
   input  logic [WORD_W-1:0] tx_data_i,
   input  logic              tx_load_i,
   output logic              tx_underrun_o,
   output logic [WORD_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   input  logic              rx_read_i,
   output logic              rx_overrun_o
);
   import spi_req_pkg::*;

   localparam int unsigned SYNC_W = 3;
   localparam logic [SYNC_W-1:0] SYNC_RST = 3'b001; // select idles high

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("spi_req_slave: WORD_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_req_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Input synchronisation and edge detection
   logic [SYNC_W-1:0] pins_s;
   logic sck_s, mosi_s, ss_n_s;
   logic sck_q, sel_q, sel;
   sck_edge_t edge_now;

   spi_req_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({sck_i, mosi_i, ss_n_i}),
      .q_o  (pins_s)
   );

   assign {sck_s, mosi_s, ss_n_s} = pins_s;
   assign sel      = !ss_n_s;
   assign edge_now = sck_classify(sck_q, sck_s, cpol_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         sck_q <= sck_s;
         sel_q <= sel;
      end
   end

   logic sample_ev, shift_ev, rx_idle, tx_take, tx_shift;

   assign sample_ev = sel && (cpha_i ? edge_now.trail : edge_now.lead);
   assign shift_ev  = sel && (cpha_i ? edge_now.lead  : edge_now.trail);
   // cpha 0: word begins at select; cpha 1: at the first leading edge.
   assign tx_take   = cpha_i ? (shift_ev && rx_idle) : (sel && !sel_q);
   assign tx_shift  = shift_ev && !(cpha_i && rx_idle);

   // Transmit buffer
   logic [WORD_W-1:0] tx_buf_q;
   logic              tx_full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf_q      <= '0;
         tx_full_q     <= 1'b0;
         tx_underrun_o <= 1'b0;
      end else begin
         tx_underrun_o <= tx_take && !tx_full_q;
         if (tx_take) tx_full_q <= 1'b0;
         if (tx_load_i) begin
            tx_buf_q  <= tx_data_i;
            tx_full_q <= 1'b1;
         end
      end
   end

   spi_req_tx #(.WORD_W(WORD_W)) i_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tx_take),
      .shift_i(tx_shift),
      .word_i (tx_buf_q),
      .bit_o  (miso_o)
   );

   spi_req_rx #(.WORD_W(WORD_W)) i_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort_i (!sel),
      .sample_i(sample_ev),
      .bit_i   (mosi_s),
      .idle_o  (rx_idle),
      .word_o  (rx_data_o),
      .done_o  (rx_valid_o)
   );

   // Receive bookkeeping, select framing and request
   logic rx_full_q, need_desel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full_q    <= 1'b0;
         rx_overrun_o <= 1'b0;
         need_desel_q <= 1'b0;
         req_n_o      <= 1'b1;
      end else begin
         rx_overrun_o <= rx_valid_o && rx_full_q;
         if (rx_valid_o)     rx_full_q <= 1'b1;
         else if (rx_read_i) rx_full_q <= 1'b0;

         if (!sel)                       need_desel_q <= 1'b0;
         else if (rx_valid_o && !cpha_i) need_desel_q <= 1'b1;

         req_n_o <= !(tx_full_q && !rx_full_q && rx_idle && !need_desel_q && !rx_valid_o);
      end
   end

   assign miso_oe_o = sel;
endmodule

// File: rtl/spi_req_slave_chk.sv
`timescale 1ns/1ps
module spi_req_slave_chk #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic ss_n_i,
   input logic cpha_i,
   input logic miso_oe_o,
   input logic req_n_o,
   input logic rx_valid_o,
   input logic rx_overrun_o
);
   logic [7:0] lo_run, hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run <= '0;
         hi_run <= '0;
      end else begin
         lo_run <= ss_n_i ? 8'd0 : ((lo_run == 8'hFF) ? lo_run : lo_run + 8'd1);
         hi_run <= !ss_n_i ? 8'd0 : ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1);
      end
   end

   AST_OE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(lo_run) >= SYNC_STAGES) |-> miso_oe_o); // R4
   AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(hi_run) >= SYNC_STAGES) |-> !miso_oe_o); // R4
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o); // R2
   AST_REQ_HIGH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> req_n_o); // R5
   AST_REQ_HOLD_LEAD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && !cpha_i) |=> req_n_o); // R6
   AST_OVERRUN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun_o |-> $past(rx_valid_o)); // R8
endmodule

bind spi_req_slave spi_req_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ss_n_i      (ss_n_i),
   .cpha_i      (cpha_i),
   .miso_oe_o   (miso_oe_o),
   .req_n_o     (req_n_o),
   .rx_valid_o  (rx_valid_o),
   .rx_overrun_o(rx_overrun_o)
);

// File: tb/test_spi_req_slave.sv
`timescale 1ns/1ps
module test_spi_req_slave;
   localparam int W = 8;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpol = 1'b0, cpha = 1'b0, sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
   logic miso, miso_oe, req_n, tx_under, rx_valid, rx_over;
   logic [W-1:0] tx_data = '0, rx_data;
   logic tx_load = 1'b0, rx_read = 1'b0;

   int n_checks = 0, n_bad = 0;
   int cnt_valid = 0, cnt_under = 0, cnt_over = 0;

   always #2.5 clk = ~clk;

   spi_req_slave #(.WORD_W(W), .SYNC_STAGES(2)) i_spi_req_slave (
      .clk(clk), .rst_n(rst_n), .cpol_i(cpol), .cpha_i(cpha),
      .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n),
      .miso_o(miso), .miso_oe_o(miso_oe), .req_n_o(req_n),
      .tx_data_i(tx_data), .tx_load_i(tx_load), .tx_underrun_o(tx_under),
      .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_read_i(rx_read),
      .rx_overrun_o(rx_over)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (rx_valid) cnt_valid <= cnt_valid + 1;
         if (tx_under) cnt_under <= cnt_under + 1;
         if (rx_over)  cnt_over  <= cnt_over + 1;
      end
   end

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic core_load(input logic [W-1:0] d);
      tx_data = d; tx_load = 1'b1; tick(1); tx_load = 1'b0;
   endtask

   task automatic core_read();
      rx_read = 1'b1; tick(1); rx_read = 1'b0;
   endtask

   // Master side of one word; the select is handled by the caller.
   task automatic spi_word(input logic [W-1:0] mo, input int nbits, output logic [W-1:0] mi);
      mi = '0;
      for (int i = 0; i < nbits; i++) begin
         int b = W - 1 - i;
         if (i == 1) check_eq("R5 request high inside word", 32'(req_n), 32'd1);
         if (!cpha) begin
            mosi = mo[b]; tick(HALF); mi[b] = miso;
            sck = ~cpol; tick(HALF); sck = cpol;
         end else begin
            sck = ~cpol; mosi = mo[b]; tick(HALF); mi[b] = miso;
            sck = cpol; tick(HALF);
         end
      end
      tick(HALF);
   endtask

   task automatic framed(input logic [W-1:0] mo, output logic [W-1:0] mi);
      ss_n = 1'b0; tick(HALF);
      spi_word(mo, W, mi);
      ss_n = 1'b1; tick(6);
   endtask

   function automatic logic [W-1:0] tx_pat(input int m, input int p);
      if (p == 0) return 8'h80;
      if (p == 1) return 8'h01;
      return 8'((m * 37 + p * 91 + 17) & 255) ^ 8'hA5;
   endfunction

   function automatic logic [W-1:0] rx_pat(input int m, input int p);
      if (p == 2) return 8'hFF;
      if (p == 3) return 8'h00;
      if (p == 4) return 8'h01;
      return 8'((m * 53 + p * 71 + 31) & 255) ^ 8'hC3;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_bad++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      logic [W-1:0] nxt, mo, mi, a_w, b_w;
      int v0, u0, o0;
      tick(5); rst_n = 1'b1; tick(4);
      check_eq("R6 request high out of reset", 32'(req_n), 32'd1);
      check_eq("R4 output disabled out of reset", 32'(miso_oe), 32'd0);
      check_eq("R2 no receive pulse out of reset", 32'(cnt_valid), 32'd0);

      for (int m = 0; m < 4; m++) begin
         cpol = m[0]; cpha = m[1]; sck = cpol; ss_n = 1'b1; tick(6);

         // R1: clock activity with select high
         v0 = cnt_valid;
         for (int k = 0; k < 2 * W; k++) begin sck = ~sck; mosi = k[0]; tick(3); end
         sck = cpol; tick(6);
         check_eq("R1 deselected clock gives no word", 32'(cnt_valid), 32'(v0));
         check_eq("R1 output disabled while deselected", 32'(miso_oe), 32'd0);

         // R2/R3/R6/R9: word sweep in this mode
         o0 = cnt_over;
         nxt = tx_pat(m, 0);
         core_load(nxt);
         for (int p = 0; p < 6; p++) begin
            logic [W-1:0] txw;
            txw = nxt;
            mo = rx_pat(m, p);
            if (!cpha || (p % 2 == 0)) begin
               tick(6);
               check_eq("R6 request low when ready", 32'(req_n), 32'd0);
               ss_n = 1'b0; tick(HALF);
               check_eq("R4 output enabled after select", 32'(miso_oe), 32'd1);
            end
            v0 = cnt_valid; u0 = cnt_under;
            spi_word(mo, W, mi); tick(4);
            check_eq("R3 R9 MISO word MSB first", 32'(mi), 32'(txw));
            check_eq("R2 R9 received word MSB first", 32'(rx_data), 32'(mo));
            check_eq("R2 one receive pulse per word", 32'(cnt_valid), 32'(v0 + 1));
            check_eq("R7 no underrun when loaded", 32'(cnt_under), 32'(u0));
            core_read();
            nxt = tx_pat(m, p + 1);
            core_load(nxt); tick(6);
            if (!cpha) begin
               check_eq("R6 request held until deselect", 32'(req_n), 32'd1);
               ss_n = 1'b1; tick(6);
               check_eq("R6 request low after deselect", 32'(req_n), 32'd0);
               check_eq("R4 output disabled after deselect", 32'(miso_oe), 32'd0);
            end else begin
               check_eq("R3 request low with select held", 32'(req_n), 32'd0);
               if (p % 2 == 1) begin
                  ss_n = 1'b1; tick(6);
                  check_eq("R4 output disabled after deselect", 32'(miso_oe), 32'd0);
               end
            end
         end
         check_eq("R8 no overrun when read in time", 32'(cnt_over), 32'(o0));

         // R7: underrun re-sends the previous word
         u0 = cnt_under;
         framed(8'h5A, mi);
         check_eq("R7 pending word sent", 32'(mi), 32'(nxt));
         core_read();
         check_eq("R7 no underrun yet", 32'(cnt_under), 32'(u0));
         framed(8'hA6, mi);
         check_eq("R7 previous word re-sent", 32'(mi), 32'(nxt));
         check_eq("R7 underrun pulse", 32'(cnt_under), 32'(u0 + 1));
         check_eq("R7 receive unaffected", 32'(rx_data), 32'hA6);

         // R8: overrun keeps the newer word
         o0 = cnt_over;
         check_eq("R6 request high with unread word", 32'(req_n), 32'd1);
         framed(8'h3C, mi);
         check_eq("R8 overrun pulse", 32'(cnt_over), 32'(o0 + 1));
         check_eq("R8 newest word kept", 32'(rx_data), 32'h3C);
         core_read(); tick(2);

         // R10: abort after three bits
         a_w = 8'hC9; b_w = 8'h72;
         core_load(a_w);
         ss_n = 1'b0; tick(HALF);
         spi_word(8'hF0, 3, mi);
         ss_n = 1'b1; tick(6);
         core_load(b_w);
         v0 = cnt_valid;
         framed(8'h96, mi);
         check_eq("R10 word after abort received whole", 32'(rx_data), 32'h96);
         check_eq("R10 word after abort sent whole", 32'(mi), 32'(b_w));
         check_eq("R10 aborted word gives no pulse", 32'(cnt_valid), 32'(v0 + 1));
         core_read(); tick(4);
      end

      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule